// File: doc/BRIEF.md
# Bridge PWM Generator with Dead-Band and Fault Shutdown

This block produces pulse-width modulated drive for up to four switch outputs, named A, B, C and D. A free-running timer behind a selectable prescaler counts out each period. The period is set by an 8-bit register, and a 10-bit duty value sets how long the output stays active. The output configuration can be single-ended, half-bridge or full-bridge. In half-bridge mode, A and B are complementary and a programmable dead band separates them. In full-bridge mode, the direction can be forward or reverse.

A fault path watches a set of selectable fault inputs. When one of them asserts, the block enters shutdown and drives each output pair to its own programmed safe state: low, high or released. Shutdown is left in one of two ways. Software can clear it, or, when automatic restart is enabled, the block leaves shutdown at the first period boundary after the fault has gone.

All settings arrive through a byte-wide write port with a 3-bit address. The register layout is:

| Address | Contents |
|---------|----------|
| 0 | bits [1:0] output configuration, bits [3:2] duty low bits, bits [7:4] mode |
| 1 | period |
| 2 | duty high byte |
| 3 | bit 0 timer run, bits [2:1] prescale |
| 4 | bits [1:0] B/D safe state, bits [3:2] A/C safe state, bits [6:4] fault select, bit 7 shutdown |
| 5 | bits [6:0] dead band, bit 7 automatic restart |

Top module: `bridge_pwm`

## Requirements
- R1: After reset, every output level and every output enable is 0, and `period_flag` stays 0. All registers reset to 0, which selects the single-output configuration with the outputs disabled.
- R2: While the timer runs, a period lasts 4*(P+1) timer ticks, where P is the period register (address 1). `period_flag` is high for exactly one clock at the last tick of each period.
- R3: The prescale field (address 3, bits [2:1]) sets clocks per tick: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R4: The duty value D is formed as {address 2, address 0 bits [3:2]}. In the single configuration (cfg=00), output A is active for the first min(D, 4*(P+1)) ticks of each period. D=0 never activates A, and D at or above 4*(P+1) keeps A active for the whole period.
- R5: Duty and period writes take effect only at the start of the next period, or at once while the timer is stopped.
- R6: The outputs are enabled only when mode bits [7:6] of address 0 are 11. Bit 4 makes A and C active-low, and bit 5 makes B and D active-low.
- R7: In half-bridge mode (cfg=10), A follows the duty signal and B is its complement. Each rising edge of A or B is delayed by the dead-band count (address 5, bits [6:0]) in clocks, and A and B are never active together. Only A and B are enabled.
- R8: In forward full-bridge mode (cfg=01), A is held active, D carries the duty signal, and B and C are inactive. In reverse full-bridge mode (cfg=11), C is held active, B carries the duty signal, and A and D are inactive. All four outputs are enabled in both modes.
- R9: A fault input whose select bit (address 4, bit 4+i) is set puts the block into shutdown within one clock. A fault input whose select bit is clear has no effect.
- R10: In shutdown, the A/C pair takes the state set by address 4 bits [3:2], and the B/D pair takes the state set by bits [1:0]. The encoding is 00 drive low, 01 drive high, and 1x output enable off.
- R11: With automatic restart off, shutdown persists after the fault clears until software writes address 4 with bit 7 at 0.
- R12: With automatic restart on (address 5, bit 7), shutdown ends only at a period boundary at which no selected fault is present. It never ends in mid-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fault_in | input | NF | Fault inputs, active high |
| pwm_out | output | 4 | Output levels, bit 0 = A through bit 3 = D |
| pwm_oe | output | 4 | Per-output drive enables |
| period_flag | output | 1 | One-clock pulse at the last tick of each period |

## Verification
The bench sweeps the duty value across three small periods, from zero through values past the period length.
- An off-by-one in the compare shows up as one active tick too many or too few.
- A design that fails to saturate at full duty drops the output at the end of the period.

It writes a new duty value in mid-period and checks that the current period keeps the old pulse width; a design without the shadow registers would shorten or stretch that period. It sweeps the dead band and looks for overlapping or missing complementary pulses. It also releases a fault in mid-period with automatic restart on; a design that restarts at once would drive normal levels before the boundary.

// File: rtl/bridge_pwm.sv
`timescale 1ns/1ps
module bridge_pwm #(
  parameter int DBW = 7,
  parameter int NF  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [NF-1:0] fault_in,
  output logic [3:0]    pwm_out,
  output logic [3:0]    pwm_oe,
  output logic          period_flag
);
  localparam logic [DBW-1:0] DB_MAX = '1;

  logic [1:0] cfg, dlsb, ps, ac_st, bd_st;
  logic [3:0] mode;
  logic [7:0] per_sh, dhi_sh, per_act;
  logic       on, sd, ar;
  logic [NF-1:0] src;
  logic [DBW-1:0] db, dbc;
  logic [3:0] pc, lim;
  logic [9:0] fine, duty_act;
  logic       tick, wrap_tick, raw, raw_d, edge_s, dead_ok, en, fault_hit;
  logic [DBW-1:0] held;
  logic [3:0] act, use_m, sdl, sdz, lvl;

  assign lim       = (ps == 2'd0) ? 4'd0 : (ps == 2'd1) ? 4'd3 : 4'd15;
  assign tick      = on && (pc == lim);
  assign wrap_tick = tick && (fine == {per_act, 2'b11});
  assign period_flag = wrap_tick;
  assign fault_hit = |(fault_in & src);
  assign en        = (mode[3:2] == 2'b11);

  assign raw     = on && (fine < duty_act);
  assign edge_s  = raw ^ raw_d;
  assign held    = edge_s ? '0 : dbc;
  assign dead_ok = (held >= db);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; dlsb <= '0; mode <= '0; per_sh <= '0; dhi_sh <= '0;
      on <= 1'b0; ps <= '0; src <= '0; ac_st <= '0; bd_st <= '0;
      ar <= 1'b0; db <= '0; sd <= 1'b0;
      pc <= '0; fine <= '0; per_act <= '0; duty_act <= '0;
      raw_d <= 1'b0; dbc <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin cfg <= wr_data[1:0]; dlsb <= wr_data[3:2]; mode <= wr_data[7:4]; end
          3'd1: per_sh <= wr_data;
          3'd2: dhi_sh <= wr_data;
          3'd3: begin on <= wr_data[0]; ps <= wr_data[2:1]; end
          3'd4: begin bd_st <= wr_data[1:0]; ac_st <= wr_data[3:2]; src <= wr_data[4 +: NF]; end
          3'd5: begin db <= wr_data[DBW-1:0]; ar <= wr_data[7]; end
          default: ;
        endcase
      end

      if (fault_hit)                         sd <= 1'b1;
      else if (wr_en && wr_addr == 3'd4)     sd <= wr_data[7];
      else if (ar && wrap_tick)              sd <= 1'b0;

      pc <= (!on || tick) ? 4'd0 : pc + 4'd1;
      if (!on)       fine <= '0;
      else if (tick) fine <= wrap_tick ? 10'd0 : fine + 10'd1;

      if (!on || wrap_tick) begin
        per_act  <= per_sh;
        duty_act <= {dhi_sh, dlsb};
      end

      raw_d <= raw;
      dbc   <= edge_s ? DBW'(1) : ((dbc == DB_MAX) ? dbc : dbc + DBW'(1));
    end
  end

  always_comb begin
    act   = 4'b0000;
    use_m = 4'b0000;
    case (cfg)
      2'b00: begin act[0] = raw; use_m = 4'b0001; end
      2'b01: begin act[0] = 1'b1; act[3] = raw; use_m = 4'b1111; end
      2'b10: begin act[0] = raw & dead_ok; act[1] = ~raw & dead_ok; use_m = 4'b0011; end
      default: begin act[2] = 1'b1; act[1] = raw; use_m = 4'b1111; end
    endcase
  end

  assign lvl = act ^ {mode[1], mode[0], mode[1], mode[0]};
  assign sdl = {bd_st[0], ac_st[0], bd_st[0], ac_st[0]};
  assign sdz = {bd_st[1], ac_st[1], bd_st[1], ac_st[1]};

  assign pwm_oe  = !en ? 4'b0000 : (sd ? (use_m & ~sdz) : use_m);
  assign pwm_out = !en ? 4'b0000 : (sd ? (sdl & use_m & ~sdz) : (lvl & use_m));

  a_r3_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    on && !tick |=> $stable(fine));
  a_r5_duty_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    on && !wrap_tick |=> $stable(duty_act));
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg == 2'b10 |-> !(act[0] && act[1]));
  a_r9_fault_enters: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> sd);
  a_r12_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd) |-> $past(wrap_tick && ar) || $past(wr_en && wr_addr == 3'd4));
endmodule

// File: tb/bridge_pwm_bench.sv
`timescale 1ns/1ps
module bridge_pwm_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fault_in = '0;
  logic [3:0] pwm_out, pwm_oe;
  logic period_flag;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_pwm u_bridge_pwm (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_in(fault_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .period_flag(period_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_flag();
    do @(negedge clk); while (!period_flag);
  endtask

  task automatic window(input int n, output int c[4]);
    for (int k = 0; k < 4; k++) c[k] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) c[k] += int'(pwm_out[k]);
    end
  endtask

  task automatic set_duty(input int d, input int cfg, input int md);
    wr(2, d >> 2);
    wr(0, (md << 4) | ((d & 3) << 2) | cfg);
  endtask

  initial begin
    #750000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c[4];
    int n, len;
    repeat (4) @(negedge clk);
    chk(pwm_oe == 4'b0 && pwm_out == 4'b0, "R1 reset outputs", int'({pwm_oe, pwm_out}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pwm_oe == 4'b0 && !period_flag, "R1 idle after reset", int'(pwm_oe), 0);

    wr(3, 1);
    for (int pi = 0; pi < 3; pi++) begin
      int p;
      p = (pi == 2) ? 3 : pi;
      len = 4 * (p + 1);
      wr(1, p);
      for (int d = 0; d <= len + 1; d++) begin
        set_duty(d, 0, 4'b1100);
        wait_flag(); wait_flag();
        window(len, c);
        chk(c[0] == ((d < len) ? d : len), "R4 duty count", c[0], (d < len) ? d : len);
      end
      wait_flag(); n = 0;
      do begin @(negedge clk); n++; end while (!period_flag);
      chk(n == len, "R2 period length", n, len);
    end

    wr(1, 2);
    for (int s = 0; s < 4; s++) begin
      int e;
      e = 12 * ((s == 0) ? 1 : (s == 1) ? 4 : 16);
      wr(3, (s << 1) | 1);
      wait_flag(); wait_flag(); n = 0;
      do begin @(negedge clk); n++; end while (!period_flag);
      chk(n == e, "R3 prescale interval", n, e);
    end

    wr(3, 1); wr(1, 3);
    set_duty(4, 0, 4'b1100);
    wait_flag(); wait_flag(); wait_flag();
    n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 2) begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'd3; end
      if (i == 3) wr_en = 1'b0;
      n += int'(pwm_out[0]);
    end
    chk(n == 4, "R5 old duty kept this period", n, 4);
    window(16, c);
    chk(c[0] == 12, "R5 new duty next period", c[0], 12);

    set_duty(5, 0, 4'b1101);
    wait_flag(); wait_flag(); window(16, c);
    chk(c[0] == 11, "R6 active-low A", c[0], 11);
    set_duty(5, 0, 4'b0000);
    wait_flag(); wait_flag(); window(16, c);
    chk(c[0] == 0 && pwm_oe == 4'b0, "R6 disabled mode", c[0], 0);
    set_duty(6, 2, 4'b1111);
    wait_flag(); wait_flag(); window(16, c);
    chk(c[0] == 10 && c[1] == 6, "R6 half-bridge inverted A", c[0], 10);

    for (int j = 0; j < 3; j++) begin
      int dbv;
      dbv = (j == 0) ? 0 : (j == 1) ? 2 : 5;
      wr(5, dbv);
      set_duty(8, 2, 4'b1100);
      wait_flag(); wait_flag(); window(16, c);
      chk(c[0] == 8 - dbv, "R7 dead band A", c[0], 8 - dbv);
      chk(c[1] == 8 - dbv, "R7 dead band B", c[1], 8 - dbv);
      chk(pwm_oe == 4'b0011, "R7 half-bridge enables", int'(pwm_oe), 3);
    end

    set_duty(5, 1, 4'b1100);
    wait_flag(); wait_flag(); window(16, c);
    chk(c[0] == 16 && c[3] == 5 && c[1] == 0 && c[2] == 0, "R8 forward", c[3], 5);
    chk(pwm_oe == 4'b1111, "R8 forward enables", int'(pwm_oe), 15);
    set_duty(5, 3, 4'b1100);
    wait_flag(); wait_flag(); window(16, c);
    chk(c[2] == 16 && c[1] == 5 && c[0] == 0 && c[3] == 0, "R8 reverse", c[1], 5);

    wr(5, 0);
    set_duty(0, 2, 4'b1100);
    wr(4, 8'h24);
    wait_flag(); wait_flag();
    @(negedge clk); fault_in = 3'b001;
    repeat (3) @(negedge clk);
    chk(pwm_out[1:0] == 2'b10, "R9 unselected fault ignored", int'(pwm_out[1:0]), 2);
    fault_in = 3'b010;
    @(negedge clk);
    chk(pwm_out[1:0] == 2'b01 && pwm_oe[1:0] == 2'b11, "R10 high/low safe states", int'(pwm_out[1:0]), 1);
    fault_in = 3'b000;
    repeat (40) @(negedge clk);
    chk(pwm_out[1:0] == 2'b01, "R11 shutdown held without restart", int'(pwm_out[1:0]), 1);
    wr(4, 8'h24);
    chk(pwm_out[1:0] == 2'b10, "R11 software clear", int'(pwm_out[1:0]), 2);

    wr(4, 8'h29);
    fault_in = 3'b010;
    @(negedge clk);
    chk(pwm_oe[1:0] == 2'b10 && pwm_out[1] == 1'b1, "R10 released A/C pair", int'(pwm_oe[1:0]), 2);
    fault_in = 3'b000;
    wr(4, 8'h29);
    chk(pwm_oe[1:0] == 2'b11, "R11 clear restores enables", int'(pwm_oe[1:0]), 3);

    wr(5, 8'h80); wr(4, 8'h24);
    @(negedge clk); fault_in = 3'b010;
    wait_flag();
    @(negedge clk);
    chk(pwm_out[1:0] == 2'b01, "R12 held across boundary while faulted", int'(pwm_out[1:0]), 1);
    repeat (2) @(negedge clk);
    fault_in = 3'b000;
    n = 0;
    do begin
      @(negedge clk);
      if (pwm_out[1:0] != 2'b01) n++;
    end while (!period_flag);
    chk(n == 0, "R12 no mid-period restart", n, 0);
    @(negedge clk);
    chk(pwm_out[1:0] == 2'b10, "R12 restart at boundary", int'(pwm_out[1:0]), 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule